// File: doc/BRIEF.md
# Exception Base Register and Handler Vector Generator

This block keeps the exception-base register of a 32-bit system-control coprocessor and turns it, together with the type of the exception being taken, into the address of the handler. Software writes the register through a simple write port and reads it back combinationally. Bit 11 of the register is a gate. A write that carries that bit set may move the two top address bits. Any other write leaves them alone, so the base stays inside the segment chosen at reset unless software unlocks it on purpose.

When an exception is requested, the block picks a vector base in one of three ways. In boot mode it uses a fixed boot base plus a displacement. For a cache error, unless an override flag is set, it uses the uncached segment mirror of the register. In every other case it uses the register with its low twelve bits cleared. It then adds the offset for that exception type. The handler address, the cause code, a strobe telling the core to save the return address, and a valid pulse all appear on registered outputs one cycle after the request. A parameter removes the gate feature altogether.

Top module: `exc_vector_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, `rd_data` reads 0x80000000 and `vec_valid` and `epc_save` are 0.
- R2: With the gate implemented, a write whose data bit 11 is 1 loads data bits 31:11 into the register and leaves bits 10:0 as they were.
- R3: A write whose data bit 11 is 0, or any write when the gate is not implemented, loads only bits 29:11 and keeps bits 31:30 and 10:0.
- R4: Register bits 10:0 never change after reset, whatever data is written.
- R5: With `boot_mode` high, the handler address is 0xBFC00200 plus the exception offset.
- R6: Cause code 30 selects the cache-error offset 0x100. Every other code selects the general offset 0x180.
- R7: For cause code 30 with `boot_mode` low and `cerr_vec_keep` low, the handler address is (0xA0000000 OR (register AND 0x1FFFF000)) + 0x100.
- R8: In any other case with `boot_mode` low, the handler address is (register AND 0xFFFFF000) plus the offset.
- R9: `epc_save` is 1 in the cycle after a request only if `exc_level` was 0 at the request. Otherwise it is 0.
- R10: `handler_pc`, `cause_out` and `vec_valid` update one cycle after `exc_req`. `vec_valid` is a one-cycle pulse, and `handler_pc` holds its value when no request is present.
- R11: When a write and a request fall in the same cycle, the handler address is built from the register value before the write.
- R12: With the gate not implemented, register bit 11 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| boot_mode | input | 1 | Boot-vector mode is active |
| cerr_vec_keep | input | 1 | Cache errors use the normal base instead of the uncached mirror |
| exc_req | input | 1 | An exception is taken this cycle |
| exc_code | input | 5 | Cause code of the exception |
| exc_level | input | 1 | Already at exception level |
| handler_pc | output | 32 | Handler address, registered |
| epc_save | output | 1 | Strobe telling the core to capture the return address |
| cause_out | output | 5 | Registered cause code |
| vec_valid | output | 1 | One-cycle pulse marking new handler outputs |

## Verification
The assertions assume that the mode flags and the cause code are settled at any clock edge where `exc_req` is high. They also assume that the exception offsets stay below 0x1000, so adding an offset never carries into the upper address bits the checker compares. The bench changes every input only on the falling clock edge. It uses only offsets 0x100 and 0x180. It drives two instances, one with the gate and one without, from the same stimulus, including a write that coincides with a request.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

   localparam int unsigned GATE_BIT    = 11;
   localparam int unsigned PROT_LO     = 30;
   localparam int unsigned VEC_ALIGN   = 12;

   typedef struct packed {
      logic [31:0] pc;
      logic [4:0]  code;
      logic        save_epc;
   } exc_vec_t;

   function automatic logic [31:0] align_down(input logic [31:0] a);
      return a & ~((32'd1 << VEC_ALIGN) - 32'd1);
   endfunction

endpackage

// File: rtl/exc_base_reg.sv
module exc_base_reg #(
   parameter int unsigned ADDR_W     = 32,
   parameter bit          WG_EN      = 1'b1,
   parameter logic [31:0] RESET_BASE = 32'h8000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] base_q
);
   import exc_vec_pkg::*;

   localparam logic [ADDR_W-1:0] RST_VAL =
      WG_EN ? RESET_BASE : (RESET_BASE & ~(32'd1 << GATE_BIT));

   logic              gate_open;
   logic [ADDR_W-1:0] base_d;

   generate
      if (WG_EN) begin : g_gate
         assign gate_open = wr_data[GATE_BIT];
      end else begin : g_nogate
         assign gate_open = 1'b0;
      end
   endgenerate

   always_comb begin
      base_d = base_q;
      if (wr_en) begin
         if (gate_open) begin
            base_d[ADDR_W-1:GATE_BIT] = wr_data[ADDR_W-1:GATE_BIT];
         end else begin
            base_d[PROT_LO-1:GATE_BIT] = wr_data[PROT_LO-1:GATE_BIT];
         end
      end
      if (!WG_EN) begin
         base_d[GATE_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= RST_VAL;
      end else begin
         base_q <= base_d;
      end
   end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned CODE_W      = 5,
   parameter logic [31:0] BOOT_BASE   = 32'hBFC0_0000,
   parameter logic [31:0] BOOT_DISP   = 32'h0000_0200,
   parameter logic [31:0] UNC_SEG     = 32'hA000_0000,
   parameter logic [31:0] SEG_MASK    = 32'h1FFF_F000,
   parameter logic [31:0] GEN_OFFSET  = 32'h0000_0180,
   parameter logic [31:0] CERR_OFFSET = 32'h0000_0100,
   parameter int unsigned CERR_CODE   = 30
) (
   input  logic [ADDR_W-1:0] base_q,
   input  logic              boot_mode,
   input  logic              cerr_vec_keep,
   input  logic [CODE_W-1:0] exc_code,
   output logic [ADDR_W-1:0] vec_pc
);
   import exc_vec_pkg::*;

   localparam logic [CODE_W-1:0] CERR_ID   = CODE_W'(CERR_CODE);
   localparam logic [ADDR_W-1:0] BOOT_VEC  = BOOT_BASE + BOOT_DISP;

   logic              is_cerr;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] vbase;

   assign is_cerr = (exc_code == CERR_ID);
   assign offset  = is_cerr ? CERR_OFFSET : GEN_OFFSET;

   always_comb begin
      if (boot_mode) begin
         vbase = BOOT_VEC;
      end else if (is_cerr && !cerr_vec_keep) begin
         vbase = UNC_SEG | (base_q & SEG_MASK);
      end else begin
         vbase = align_down(base_q);
      end
   end

   assign vec_pc = vbase + offset;

endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req,
   input  logic              exc_level,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [ADDR_W-1:0] vec_pc,
   output logic [ADDR_W-1:0] handler_pc,
   output logic [CODE_W-1:0] cause_out,
   output logic              epc_save,
   output logic              vec_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         handler_pc <= '0;
         cause_out  <= '0;
         epc_save   <= 1'b0;
         vec_valid  <= 1'b0;
      end else begin
         vec_valid <= exc_req;
         epc_save  <= exc_req && !exc_level;
         if (exc_req) begin
            handler_pc <= vec_pc;
            cause_out  <= exc_code;
         end
      end
   end

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned CODE_W      = 5,
   parameter bit          WG_EN       = 1'b1,
   parameter logic [31:0] RESET_BASE  = 32'h8000_0000,
   parameter logic [31:0] BOOT_BASE   = 32'hBFC0_0000,
   parameter logic [31:0] GEN_OFFSET  = 32'h0000_0180,
   parameter logic [31:0] CERR_OFFSET = 32'h0000_0100,
   parameter int unsigned CERR_CODE   = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_data,
   input  logic              boot_mode,
   input  logic              cerr_vec_keep,
   input  logic              exc_req,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              exc_level,
   output logic [ADDR_W-1:0] handler_pc,
   output logic              epc_save,
   output logic [CODE_W-1:0] cause_out,
   output logic              vec_valid
);

   localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

   generate
      if (ADDR_W != 32) begin : g_bad_width
         $error("exc_vector_unit: only 32-bit addresses are supported");
      end
      if (CERR_CODE > MAX_CODE) begin : g_bad_code
         $error("exc_vector_unit: cache-error code does not fit CODE_W");
      end
      if (GEN_OFFSET >= 32'h1000 || CERR_OFFSET >= 32'h1000) begin : g_bad_off
         $error("exc_vector_unit: vector offsets must stay below 4 KiB");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] vec_pc;

   exc_base_reg #(
      .ADDR_W     (ADDR_W),
      .WG_EN      (WG_EN),
      .RESET_BASE (RESET_BASE)
   ) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .base_q  (base_q)
   );

   exc_vector_calc #(
      .ADDR_W      (ADDR_W),
      .CODE_W      (CODE_W),
      .BOOT_BASE   (BOOT_BASE),
      .GEN_OFFSET  (GEN_OFFSET),
      .CERR_OFFSET (CERR_OFFSET),
      .CERR_CODE   (CERR_CODE)
   ) u_calc (
      .base_q        (base_q),
      .boot_mode     (boot_mode),
      .cerr_vec_keep (cerr_vec_keep),
      .exc_code      (exc_code),
      .vec_pc        (vec_pc)
   );

   exc_capture #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .exc_req    (exc_req),
      .exc_level  (exc_level),
      .exc_code   (exc_code),
      .vec_pc     (vec_pc),
      .handler_pc (handler_pc),
      .cause_out  (cause_out),
      .epc_save   (epc_save),
      .vec_valid  (vec_valid)
   );

   assign rd_data = base_q;

endmodule

// File: rtl/exc_vector_checker.sv
module exc_vector_checker #(
   parameter int unsigned CODE_W    = 5,
   parameter bit          WG_EN     = 1'b1,
   parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000,
   parameter int unsigned CERR_CODE = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [31:0]       wr_data,
   input logic [31:0]       rd_data,
   input logic              boot_mode,
   input logic              cerr_vec_keep,
   input logic              exc_req,
   input logic [CODE_W-1:0] exc_code,
   input logic              exc_level,
   input logic [31:0]       handler_pc,
   input logic              epc_save,
   input logic [CODE_W-1:0] cause_out,
   input logic              vec_valid
);

   localparam logic [19:0]       BOOT_HI = BOOT_BASE[31:12];
   localparam logic [CODE_W-1:0] CERR_ID = CODE_W'(CERR_CODE);
   localparam logic              GATE_ON = WG_EN;

   logic gated_wr;
   logic cerr_unc;
   assign gated_wr = wr_en && GATE_ON && wr_data[11];
   assign cerr_unc = exc_req && !boot_mode && !cerr_vec_keep && (exc_code == CERR_ID);

   generate
      if (WG_EN) begin : g_gate_chk
         assert_gated_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            gated_wr |=> rd_data[31:11] == $past(wr_data[31:11]));
      end else begin : g_nogate_chk
         assert_gate_bit_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[11] == 1'b0);
      end
   endgenerate

   assert_plain_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !gated_wr) |=> rd_data[31:30] == $past(rd_data[31:30]));

   assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(rd_data[10:0]));

   assert_boot_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && boot_mode) |=> handler_pc[31:12] == BOOT_HI);

   assert_cerr_segment_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cerr_unc |=> handler_pc[31:29] == 3'b101);

   // Also covers R11: the reference is the register value before any same-cycle write
   assert_normal_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !boot_mode && !cerr_unc) |=> handler_pc[31:12] == $past(rd_data[31:12]));

   assert_epc_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !exc_level) |=> epc_save);

   assert_epc_skipped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req || exc_level) |=> !epc_save);

   assert_outputs_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (vec_valid && cause_out == $past(exc_code)));

   assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |=> (!vec_valid && $stable(handler_pc) && $stable(cause_out)));

endmodule

bind exc_vector_unit exc_vector_checker #(
   .CODE_W    (CODE_W),
   .WG_EN     (WG_EN),
   .BOOT_BASE (BOOT_BASE),
   .CERR_CODE (CERR_CODE)
) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .boot_mode     (boot_mode),
   .cerr_vec_keep (cerr_vec_keep),
   .exc_req       (exc_req),
   .exc_code      (exc_code),
   .exc_level     (exc_level),
   .handler_pc    (handler_pc),
   .epc_save      (epc_save),
   .cause_out     (cause_out),
   .vec_valid     (vec_valid)
);

// File: tb/test_exc_vector_unit.sv
`timescale 1ns/1ps
module test_exc_vector_unit;

   typedef struct packed {
      logic        wr;
      logic [31:0] wdata;
      logic        boot;
      logic        keep;
      logic [4:0]  code;
      logic        lvl;
      logic [31:0] exp_rd;
      logic [31:0] exp_pc;
      logic        exp_epc;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t TABLE [NVEC] = '{
      // R8 R6: reset base, general offset
      '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 5'd0,  1'b0, 32'h8000_0000, 32'h8000_0180, 1'b1},
      // R3 R9: plain write keeps bits 31:30, exception level set
      '{1'b1, 32'h1234_5000, 1'b0, 1'b0, 5'd0,  1'b1, 32'h9234_5000, 32'h9234_5180, 1'b0},
      // R7: cache error forced into the uncached mirror
      '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 5'd30, 1'b0, 32'h9234_5000, 32'hB234_5100, 1'b1},
      // R8 R6: cache error with override uses the normal base
      '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 5'd30, 1'b0, 32'h9234_5000, 32'h9234_5100, 1'b1},
      // R5: boot mode, general offset
      '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 5'd0,  1'b0, 32'h9234_5000, 32'hBFC0_0380, 1'b1},
      // R5 R6: boot mode, cache error offset
      '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 5'd30, 1'b0, 32'h9234_5000, 32'hBFC0_0300, 1'b1},
      // R2: gated write moves bits 31:30
      '{1'b1, 32'h40AB_C800, 1'b0, 1'b0, 5'd4,  1'b0, 32'h40AB_C800, 32'h40AB_C180, 1'b1},
      // R2 R4 R7: all-ones gated write, low bits stay
      '{1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'd30, 1'b1, 32'hFFFF_F800, 32'hBFFF_F100, 1'b0},
      // R3: plain zero write clears 29:11 only
      '{1'b1, 32'h0000_0000, 1'b0, 1'b0, 5'd7,  1'b0, 32'hC000_0000, 32'hC000_0180, 1'b1},
      // R3 R4: low data bits ignored
      '{1'b1, 32'h0000_1234, 1'b0, 1'b0, 5'd0,  1'b0, 32'hC000_1000, 32'hC000_1180, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        boot_mode = 1'b0;
   logic        cerr_vec_keep = 1'b0;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_code = '0;
   logic        exc_level = 1'b0;

   logic [31:0] rd_data, handler_pc, rd_ng, pc_ng;
   logic        epc_save, vec_valid, epc_ng, valid_ng;
   logic [4:0]  cause_out, cause_ng;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   exc_vector_unit i_exc_vector_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .boot_mode(boot_mode), .cerr_vec_keep(cerr_vec_keep), .exc_req(exc_req),
      .exc_code(exc_code), .exc_level(exc_level), .handler_pc(handler_pc),
      .epc_save(epc_save), .cause_out(cause_out), .vec_valid(vec_valid)
   );

   exc_vector_unit #(.WG_EN(1'b0)) i_exc_vector_unit_nogate (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_ng),
      .boot_mode(boot_mode), .cerr_vec_keep(cerr_vec_keep), .exc_req(exc_req),
      .exc_code(exc_code), .exc_level(exc_level), .handler_pc(pc_ng),
      .epc_save(epc_ng), .cause_out(cause_ng), .vec_valid(valid_ng)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] last_pc;
      repeat (3) @(negedge clk);
      check("R1 reset rd", rd_data, 32'h8000_0000);
      check("R1 reset valid", {31'd0, vec_valid}, 32'd0);
      check("R1 reset epc", {31'd0, epc_save}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release rd", rd_data, 32'h8000_0000);
      check("R12 reset bit11", {31'd0, rd_ng[11]}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         if (TABLE[i].wr) begin
            wr_en   = 1'b1;
            wr_data = TABLE[i].wdata;
            @(negedge clk);
            wr_en = 1'b0;
         end
         exc_req       = 1'b1;
         boot_mode     = TABLE[i].boot;
         cerr_vec_keep = TABLE[i].keep;
         exc_code      = TABLE[i].code;
         exc_level     = TABLE[i].lvl;
         @(negedge clk);
         exc_req = 1'b0;
         check($sformatf("R2 R3 R4 rd vec %0d", i), rd_data, TABLE[i].exp_rd);
         check($sformatf("R5 R6 R7 R8 pc vec %0d", i), handler_pc, TABLE[i].exp_pc);
         check($sformatf("R9 epc vec %0d", i), {31'd0, epc_save}, {31'd0, TABLE[i].exp_epc});
         check($sformatf("R10 cause vec %0d", i), {27'd0, cause_out}, {27'd0, TABLE[i].code});
         check($sformatf("R10 valid vec %0d", i), {31'd0, vec_valid}, 32'd1);
      end

      // R10: idle cycle, outputs hold and pulse drops
      last_pc = handler_pc;
      exc_code = 5'd9;
      @(negedge clk);
      check("R10 idle valid", {31'd0, vec_valid}, 32'd0);
      check("R10 idle epc", {31'd0, epc_save}, 32'd0);
      check("R10 idle pc held", handler_pc, last_pc);
      check("R10 idle cause held", {27'd0, cause_out}, 32'd0);

      // R11: write and exception in the same cycle
      wr_en     = 1'b1;
      wr_data   = 32'h0000_0000;
      exc_req   = 1'b1;
      boot_mode = 1'b0;
      exc_code  = 5'd0;
      exc_level = 1'b0;
      @(negedge clk);
      wr_en   = 1'b0;
      exc_req = 1'b0;
      check("R11 pc from old value", handler_pc, 32'hC000_1180);
      check("R11 rd after write", rd_data, 32'hC000_0000);

      // R12: no gate, a write with bit 11 set acts as a plain write
      wr_en   = 1'b1;
      wr_data = 32'h40AB_C800;
      @(negedge clk);
      wr_en = 1'b0;
      check("R12 nogate rd", rd_ng, 32'h80AB_C000);
      check("R12 nogate bit11", {31'd0, rd_ng[11]}, 32'd0);
      check("R2 gated rd", rd_data, 32'h40AB_C800);

      // R1: reset again restores the default base
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset rd", rd_data, 32'h8000_0000);
      check("R1 re-reset nogate rd", rd_ng, 32'h8000_0000);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule